// File: doc/BRIEF.md
# CPU-to-Debugger Mailbox Byte

This block gives a running CPU a one-byte channel to an external debugger. The CPU writes a byte into the mailbox. That write also raises a pending flag. The debugger reads the byte through its own port and acknowledges it, and the acknowledge drops the flag. When the CPU reads the mailbox it sees the pending flag in the top bit and the low seven stored bits below it. This lets software poll until the debugger has taken the byte.

The mailbox shares its CPU address with an ordinary I/O register. An access at that address reaches the mailbox only when two conditions hold: the debug-enable fuse is programmed, and the debugger has set its map-enable bit. In every other case the access goes to the ordinary register. The block keeps a model of the debug-enable fuse and of two lock bits. While any lock bit is programmed, a request to program the fuse is refused. A chip erase clears the lock bits, and after it the request is accepted. The debugger port works only while the test-port fuse input is high and the test-port disable input is low.

Top module: `dbg_mailbox_top`

## Requirements
- R1: A CPU write (`cpu_sel` and `cpu_wr` high) while the mailbox is mapped stores `cpu_wdata` and sets the pending flag. Both appear on `dbg_data` and `dbg_dirty` one clock later.
- R2: A CPU read (`cpu_sel` and `cpu_rd` high) of the mapped mailbox returns the pending flag in bit 7 and stored bits 6..0 in bits 6..0, in the same cycle. `cpu_rdata` is 0 when no read is strobed.
- R3: `dbg_ack` with the port active clears the pending flag one clock later. The stored byte is left unchanged.
- R4: If a mailbox write and an active `dbg_ack` fall in the same cycle, the write wins and the flag is set afterwards.
- R5: The mailbox is mapped (`mbox_routed` = 1) only when the debug-enable fuse and the map-enable bit are both 1. When it is not mapped, CPU writes and reads at the address use the ordinary register and leave the mailbox untouched.
- R6: After reset, every register is 0: the stored byte, the flag, the ordinary register, map enable, the fuse and the lock bits.
- R7: `dbgen_req` programs the fuse one clock later only if `lock_state` is 0. Otherwise the request is refused. `lock_pgm_req` ORs `lock_pgm_val` into `lock_state`.
- R8: `chip_erase` clears the lock bits, the stored byte, the pending flag and map enable one clock later. It leaves the fuse and the ordinary register unchanged. In an erase cycle, mailbox writes, acknowledges, map writes, lock requests and fuse requests are ignored.
- R9: `port_active` = `tap_fuse_pgm` AND NOT `tap_disable`. While the port is inactive, `dbg_ack` and `dbg_map_wr` have no effect, and `dbg_data` and `dbg_dirty` read 0.
- R10: A CPU read strobe never changes the pending flag.
- R11: `dbg_data` carries all eight stored bits, including bit 7, independent of the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_sel | input | 1 | CPU address matches the shared location |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| dbg_data | output | 8 | Stored byte seen by the debugger |
| dbg_dirty | output | 1 | Pending flag seen by the debugger |
| dbg_ack | input | 1 | Debugger has consumed the byte |
| dbg_map_wr | input | 1 | Debugger writes map enable |
| dbg_map_val | input | 1 | New map-enable value |
| tap_fuse_pgm | input | 1 | Test-port fuse programmed |
| tap_disable | input | 1 | Test-port disable control bit |
| dbgen_req | input | 1 | Request to program the debug-enable fuse |
| lock_pgm_req | input | 1 | Request to program lock bits |
| lock_pgm_val | input | 2 | Lock bits to program |
| chip_erase | input | 1 | Chip erase pulse |
| dbgen_fuse | output | 1 | Debug-enable fuse state |
| lock_state | output | 2 | Programmed lock bits |
| port_active | output | 1 | Debugger port usable |
| mbox_routed | output | 1 | Shared address reaches the mailbox |

## Verification
Two kinds of result fall in different cycles. CPU read data, `port_active`, and the gating of `dbg_data` and `dbg_dirty` are combinational, so they are due in the same cycle as their inputs. Every stored effect shows one clock after the edge that samples its request: the byte and flag, the ordinary register, map enable, the fuse and the lock bits. The bench drives inputs just after a rising edge and compares every output with its reference at the following falling edge. It then advances the reference model at the rising edge, using the same inputs the design samples. As a result, a registered effect is first compared one full cycle after its stimulus, and a combinational one within the same cycle.

// File: rtl/dbg_mbox_pkg.sv
package dbg_mbox_pkg;
  typedef enum logic {
    ROUTE_STD  = 1'b0,
    ROUTE_MBOX = 1'b1
  } route_e;
endpackage

// File: rtl/mbox_gate.sv
module mbox_gate #(
  parameter int LOCK_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tap_fuse_pgm,
  input  logic                  tap_disable,
  input  logic                  map_wr,
  input  logic                  map_val,
  input  logic                  fuse_req,
  input  logic                  lock_req,
  input  logic [LOCK_W-1:0]     lock_val,
  input  logic                  erase,
  output logic                  port_active,
  output logic                  fuse_q,
  output logic [LOCK_W-1:0]     lock_q,
  output dbg_mbox_pkg::route_e  route
);
  import dbg_mbox_pkg::*;

  logic              map_q, map_d, map_en;
  logic              fuse_d, fuse_en;
  logic [LOCK_W-1:0] lock_d;
  logic              lock_en;
  logic              locked;

  assign port_active = tap_fuse_pgm & ~tap_disable;
  assign locked      = |lock_q;
  assign route       = (fuse_q & map_q) ? ROUTE_MBOX : ROUTE_STD;

  always_comb begin
    map_en  = erase | (port_active & map_wr);
    map_d   = erase ? 1'b0 : map_val;
    lock_en = erase | lock_req;
    lock_d  = erase ? '0 : (lock_q | lock_val);
    fuse_en = ~erase & fuse_req & ~locked;
    fuse_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q  <= 1'b0;
      lock_q <= '0;
      fuse_q <= 1'b0;
    end else begin
      if (map_en)  map_q  <= map_d;
      if (lock_en) lock_q <= lock_d;
      if (fuse_en) fuse_q <= fuse_d;
    end
  end

  p_lock_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_req && (lock_q != '0) && !fuse_q) |=> !fuse_q);
  p_fuse_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_req && (lock_q == '0) && !erase) |=> fuse_q);
  p_erase_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (lock_q == '0) && (route == ROUTE_STD));
  p_erase_keeps_fuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> fuse_q == $past(fuse_q));
  p_port_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_active && !erase) |=> map_q == $past(map_q));
endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack_en,
  output logic [DATA_W-1:0] data_q,
  output logic              dirty_q
);
  logic [DATA_W-1:0] data_d;
  logic              data_en, dirty_d, dirty_en;

  always_comb begin
    data_en  = erase | wr_en;
    data_d   = erase ? '0 : wdata;
    dirty_en = erase | wr_en | ack_en;
    if (erase)      dirty_d = 1'b0;
    else if (wr_en) dirty_d = 1'b1;
    else            dirty_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      dirty_q <= 1'b0;
    end else begin
      if (data_en)  data_q  <= data_d;
      if (dirty_en) dirty_q <= dirty_d;
    end
  end

  p_wr_sets_dirty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase) |=> dirty_q && (data_q == $past(wdata)));
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && !wr_en && !erase) |=> !dirty_q && $stable(data_q));
  p_write_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && wr_en && !erase) |=> dirty_q);
  p_flag_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !ack_en && !erase) |=> $stable(dirty_q));
endmodule

// File: rtl/mbox_iosel.sv
module mbox_iosel #(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dbg_mbox_pkg::route_e route,
  input  logic                 sel,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [DATA_W-1:0]    mbox_data,
  input  logic                 mbox_dirty,
  output logic                 mbox_wr,
  output logic [DATA_W-1:0]    rdata
);
  import dbg_mbox_pkg::*;

  localparam int FLAG_BIT = DATA_W - 1;

  logic [DATA_W-1:0] std_q;
  logic              std_en;
  logic [DATA_W-1:0] mbox_view;
  logic              to_mbox;

  assign to_mbox = (route == ROUTE_MBOX);
  assign mbox_wr = sel & wr & to_mbox;
  assign std_en  = sel & wr & ~to_mbox;

  for (genvar b = 0; b < DATA_W; b++) begin : g_view
    if (b == FLAG_BIT) begin : g_flag
      assign mbox_view[b] = mbox_dirty;
    end else begin : g_bit
      assign mbox_view[b] = mbox_data[b];
    end
  end

  always_comb begin
    if (!(sel && rd)) rdata = '0;
    else if (to_mbox) rdata = mbox_view;
    else              rdata = std_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      std_q <= '0;
    else if (std_en) std_q <= wdata;
  end

  p_std_untouched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && to_mbox) |=> $stable(std_q));
  p_read_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rd && to_mbox) |-> rdata[FLAG_BIT] == mbox_dirty);
endmodule

// File: rtl/dbg_mailbox_top.sv
module dbg_mailbox_top #(
  parameter int DATA_W = 8,
  parameter int LOCK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [DATA_W-1:0] dbg_data,
  output logic              dbg_dirty,
  input  logic              dbg_ack,
  input  logic              dbg_map_wr,
  input  logic              dbg_map_val,
  input  logic              tap_fuse_pgm,
  input  logic              tap_disable,
  input  logic              dbgen_req,
  input  logic              lock_pgm_req,
  input  logic [LOCK_W-1:0] lock_pgm_val,
  input  logic              chip_erase,
  output logic              dbgen_fuse,
  output logic [LOCK_W-1:0] lock_state,
  output logic              port_active,
  output logic              mbox_routed
);
  import dbg_mbox_pkg::*;

  route_e            route;
  logic              mbox_wr, ack_en, dirty_q;
  logic [DATA_W-1:0] data_q;

  mbox_gate #(.LOCK_W(LOCK_W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .tap_fuse_pgm(tap_fuse_pgm), .tap_disable(tap_disable),
    .map_wr(dbg_map_wr), .map_val(dbg_map_val),
    .fuse_req(dbgen_req), .lock_req(lock_pgm_req), .lock_val(lock_pgm_val),
    .erase(chip_erase), .port_active(port_active),
    .fuse_q(dbgen_fuse), .lock_q(lock_state), .route(route)
  );

  assign ack_en = dbg_ack & port_active & ~chip_erase;

  mbox_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .erase(chip_erase),
    .wr_en(mbox_wr & ~chip_erase), .wdata(cpu_wdata), .ack_en(ack_en),
    .data_q(data_q), .dirty_q(dirty_q)
  );

  mbox_iosel #(.DATA_W(DATA_W)) u_iosel (
    .clk(clk), .rst_n(rst_n), .route(route),
    .sel(cpu_sel), .wr(cpu_wr), .rd(cpu_rd), .wdata(cpu_wdata),
    .mbox_data(data_q), .mbox_dirty(dirty_q),
    .mbox_wr(mbox_wr), .rdata(cpu_rdata)
  );

  assign mbox_routed = (route == ROUTE_MBOX);
  assign dbg_data    = port_active ? data_q : '0;
  assign dbg_dirty   = port_active & dirty_q;

  p_idle_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !port_active |-> (dbg_data == '0) && !dbg_dirty);
  p_dbg_full_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && cpu_wr && mbox_routed && !chip_erase && port_active && $stable(port_active))
      |=> !port_active || (dbg_data == $past(cpu_wdata)));
endmodule

// File: tb/dbg_mailbox_top_test.sv
module dbg_mailbox_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_sel, cpu_wr, cpu_rd;
  logic [7:0] cpu_wdata, cpu_rdata, dbg_data;
  logic       dbg_dirty, dbg_ack, dbg_map_wr, dbg_map_val;
  logic       tap_fuse_pgm, tap_disable, dbgen_req, lock_pgm_req, chip_erase;
  logic [1:0] lock_pgm_val, lock_state;
  logic       dbgen_fuse, port_active, mbox_routed;

  int checks = 0;
  int errors = 0;
  string cur_req = "R6";

  // reference state
  bit [7:0] m_data, m_std;
  bit       m_dirty, m_map, m_fuse;
  bit [1:0] m_lock;

  always #5 clk = ~clk;

  dbg_mailbox_top uut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dbg_data(dbg_data),
    .dbg_dirty(dbg_dirty), .dbg_ack(dbg_ack), .dbg_map_wr(dbg_map_wr),
    .dbg_map_val(dbg_map_val), .tap_fuse_pgm(tap_fuse_pgm), .tap_disable(tap_disable),
    .dbgen_req(dbgen_req), .lock_pgm_req(lock_pgm_req), .lock_pgm_val(lock_pgm_val),
    .chip_erase(chip_erase), .dbgen_fuse(dbgen_fuse), .lock_state(lock_state),
    .port_active(port_active), .mbox_routed(mbox_routed)
  );

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit act_p, route;
    bit [7:0] rd;
    act_p = tap_fuse_pgm && !tap_disable;
    route = m_fuse && m_map;
    if (!(cpu_sel && cpu_rd)) rd = 8'h00;
    else if (route)           rd = {m_dirty, m_data[6:0]};
    else                      rd = m_std;
    chk("cpu_rdata", cpu_rdata, rd);
    chk("dbg_data", dbg_data, act_p ? m_data : 8'h00);
    chk("dbg_dirty", dbg_dirty, act_p && m_dirty);
    chk("port_active", port_active, act_p);
    chk("mbox_routed", mbox_routed, route);
    chk("dbgen_fuse", dbgen_fuse, m_fuse);
    chk("lock_state", lock_state, m_lock);
  endtask

  task automatic model_step();
    bit act_p, route, wmb;
    act_p = tap_fuse_pgm && !tap_disable;
    route = m_fuse && m_map;
    if (!rst_n) begin
      m_data = 0; m_std = 0; m_dirty = 0; m_map = 0; m_fuse = 0; m_lock = 0;
      return;
    end
    if (cpu_sel && cpu_wr && !route) m_std = cpu_wdata;
    if (chip_erase) begin
      m_data = 0; m_dirty = 0; m_map = 0; m_lock = 0;
    end else begin
      wmb = cpu_sel && cpu_wr && route;
      if (wmb) begin
        m_data = cpu_wdata; m_dirty = 1;
      end else if (act_p && dbg_ack) m_dirty = 0;
      if (act_p && dbg_map_wr) m_map = dbg_map_val;
      if (dbgen_req && m_lock == 0) m_fuse = 1;
      if (lock_pgm_req) m_lock = m_lock | lock_pgm_val;
    end
  endtask

  task automatic idle_in();
    cpu_sel = 0; cpu_wr = 0; cpu_rd = 0; cpu_wdata = 0;
    dbg_ack = 0; dbg_map_wr = 0; dbg_map_val = 0;
    dbgen_req = 0; lock_pgm_req = 0; lock_pgm_val = 0; chip_erase = 0;
  endtask

  // one cycle: inputs are already driven; compare at falling edge, advance at rising edge
  task automatic tick();
    @(negedge clk);
    compare();
    @(posedge clk);
    model_step();
    #1;
    idle_in();
  endtask

  task automatic cpu_write(bit [7:0] d);
    cpu_sel = 1; cpu_wr = 1; cpu_wdata = d; tick();
  endtask

  task automatic cpu_read();
    cpu_sel = 1; cpu_rd = 1; tick();
  endtask

  initial begin
    rst_n = 0; tap_fuse_pgm = 0; tap_disable = 0;
    idle_in();
    cur_req = "R6"; // reset state
    repeat (3) tick();
    rst_n = 1;
    tick();
    cpu_read();

    cur_req = "R9"; // port inactive: map write and ack ignored
    dbg_map_wr = 1; dbg_map_val = 1; tick();
    dbg_ack = 1; tick();
    tap_fuse_pgm = 1; tap_disable = 1; dbg_map_wr = 1; dbg_map_val = 1; tick();
    tap_disable = 0; tick();

    cur_req = "R5"; // fuse still 0: ordinary register used
    dbg_map_wr = 1; dbg_map_val = 1; tick();
    cpu_write(8'hA5);
    cpu_read();

    cur_req = "R7"; // lock blocks fuse
    lock_pgm_req = 1; lock_pgm_val = 2'b01; tick();
    dbgen_req = 1; tick();
    lock_pgm_req = 1; lock_pgm_val = 2'b10; tick();
    dbgen_req = 1; tick();

    cur_req = "R8"; // erase clears locks and map enable
    chip_erase = 1; dbgen_req = 1; tick();
    tick();
    cur_req = "R7";
    dbgen_req = 1; tick();
    cur_req = "R5";
    dbg_map_wr = 1; dbg_map_val = 1; tick();
    cpu_read();

    cur_req = "R1";
    cpu_write(8'hC3);
    tick();
    cur_req = "R2";
    cpu_read();
    cpu_write(8'h3C);
    cpu_read();
    cur_req = "R11";
    cpu_write(8'h80);
    tick();
    cur_req = "R10";
    repeat (3) cpu_read();
    cur_req = "R3";
    dbg_ack = 1; tick();
    cpu_read();
    cur_req = "R4";
    cpu_sel = 1; cpu_wr = 1; cpu_wdata = 8'h5A; dbg_ack = 1; tick();
    cpu_read();
    cur_req = "R9";
    tap_disable = 1; dbg_ack = 1; tick();
    dbg_map_wr = 1; dbg_map_val = 0; tick();
    tap_disable = 0; tick();
    cur_req = "R5";
    dbg_map_wr = 1; dbg_map_val = 0; tick();
    cpu_write(8'h11);
    cpu_read();
    dbg_map_wr = 1; dbg_map_val = 1; tick();
    cpu_read();
    cur_req = "R8";
    cpu_sel = 1; cpu_wr = 1; cpu_wdata = 8'hFF; chip_erase = 1; tick();
    cpu_read();

    cur_req = "R1"; // mixed traffic
    for (int i = 0; i < 400; i++) begin
      cpu_sel      = $urandom_range(0, 1);
      cpu_wr       = $urandom_range(0, 1);
      cpu_rd       = $urandom_range(0, 1);
      cpu_wdata    = 8'($urandom);
      dbg_ack      = $urandom_range(0, 2) == 0;
      dbg_map_wr   = $urandom_range(0, 7) == 0;
      dbg_map_val  = $urandom_range(0, 3) != 0;
      dbgen_req    = $urandom_range(0, 15) == 0;
      lock_pgm_req = $urandom_range(0, 31) == 0;
      lock_pgm_val = 2'($urandom);
      chip_erase   = $urandom_range(0, 23) == 0;
      tap_disable  = $urandom_range(0, 9) == 0;
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule